// File: doc/BRIEF.md
# Integer Execution Unit with Signed-Overflow Trap

This block is the integer arithmetic stage of a load-store processor core. It takes two 32-bit register operands, a 16-bit immediate, a flag that selects the immediate in place of the second register, and an operation code. From these it produces a 32-bit result in the same cycle. The unit performs addition and subtraction in two forms: a trapping form that reports signed overflow and a wrapping form that never does. It also performs less-than comparisons that return 0 or 1, with a two's-complement variant and a magnitude variant, and a logical left shift by a 5-bit amount.

When a trapping operation overflows, the unit raises a trap flag and drops its register write enable, so that the destination register keeps its old value. The wrapped result is still driven so that the exception logic can inspect it. The register file, decode, exception handling and any staging registers belong to the surrounding core.

Top module: `alu_exec_unit`

## Requirements
- R1: Operation code 0 (trapping add) drives the 32-bit wrapped sum of A and the second operand. It sets `ovf_trap` exactly when the true signed sum lies outside -2^31 to 2^31-1.
- R2: Operation codes 2 (wrapping add) and 3 (wrapping subtract) drive the same wrapped 32-bit value as codes 0 and 1 on the same inputs. They never set `ovf_trap`.
- R3: When `imm_sel` is 1, the second operand of codes 0 to 5 is `imm` sign-extended from bit 15 to 32 bits. This applies to the wrapping and magnitude-compare codes as well. When `imm_sel` is 0, the second operand is `op_b`.
- R4: Operation code 4 drives 1 when A is less than the second operand as two's-complement numbers and 0 otherwise. Bits 31..1 are zero.
- R5: Operation code 5 drives 1 when A is less than the second operand as unsigned numbers and 0 otherwise. Bits 31..1 are zero.
- R6: `wr_en` is 1 for every defined code unless `ovf_trap` is 1, in which case it is 0 and `result` still carries the wrapped value.
- R7: Operation code 6 drives A shifted left by `imm[4:0]` with zeros entering at bit 0. `op_b` and `imm_sel` have no effect on it.
- R8: Operation code 1 (trapping subtract) drives the wrapped value A minus the second operand. It sets `ovf_trap` exactly when the true signed difference lies outside -2^31 to 2^31-1.
- R9: Operation codes 7 to 15 drive `result` 0, `wr_en` 0 and `ovf_trap` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First register operand (also the shift source) |
| op_b | input | 32 | Second register operand |
| imm | input | 16 | Signed immediate; bits 4..0 give the shift amount |
| imm_sel | input | 1 | 1 selects the extended immediate as second operand |
| op_code | input | 4 | Operation select, encodings as in the requirements |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow on a trapping add or subtract |
| wr_en | output | 1 | Destination register write enable |

## Verification
The unit holds no state, so any wrong internal path shows at the ports in the same cycle as the stimulus. A mis-wired operand select or sign extension corrupts the sum and comparison results for negative immediates. An overflow detector that uses the wrong operand sign either misses traps or raises false ones near the ±2^31 boundary, and `wr_en` follows it in the same cycle. A faulty shifter stage damages only those shift amounts whose matching bit is set, so the bench covers every amount from 0 to 31 as well as random operands.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD_T  = 4'd0,
        OPC_SUB_T  = 4'd1,
        OPC_ADD_W  = 4'd2,
        OPC_SUB_W  = 4'd3,
        OPC_LT_S   = 4'd4,
        OPC_LT_U   = 4'd5,
        OPC_SHL    = 4'd6
    } alu_opc_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             ovf_o
);
    logic [WIDTH-1:0] b_eff_d;

    always_comb begin
        b_eff_d = sub_i ? ~b_i : b_i;
        sum_o   = a_i + b_eff_d + {{(WIDTH-1){1'b0}}, sub_i};
        // operands agree in sign, result disagrees
        ovf_o   = (a_i[WIDTH-1] == b_eff_d[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
    end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             lt_s_o,
    output logic             lt_u_o
);
    always_comb begin
        lt_u_o = a_i < b_i;
        // differing signs decide directly; otherwise magnitude order holds
        lt_s_o = (a_i[WIDTH-1] != b_i[WIDTH-1]) ? a_i[WIDTH-1] : lt_u_o;
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [SHAMT_W-1:0] amt_i,
    output logic [WIDTH-1:0]   y_o
);
    logic [WIDTH-1:0] stage_d [SHAMT_W+1];

    assign stage_d[0] = a_i;

    generate
        for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
            assign stage_d[s+1] = amt_i[s] ? (stage_d[s] << (1 << s)) : stage_d[s];
        end
    endgenerate

    assign y_o = stage_d[SHAMT_W];
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             imm_sel,
    input  logic [OPC_W-1:0] op_code,
    output logic [WIDTH-1:0] result,
    output logic             ovf_trap,
    output logic             wr_en
);
    localparam int SHAMT_W = $clog2(WIDTH);

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             trap;
        logic             we;
    } alu_out_t;

    logic [WIDTH-1:0]   opnd_b_d;
    logic               is_sub_d;
    logic [WIDTH-1:0]   sum_d;
    logic               add_ovf_d;
    logic               lt_s_d;
    logic               lt_u_d;
    logic [WIDTH-1:0]   shl_d;
    logic [SHAMT_W-1:0] shamt_d;
    alu_out_t           out_d;

    always_comb begin
        opnd_b_d = imm_sel ? {{(WIDTH-IMM_W){imm[IMM_W-1]}}, imm} : op_b;
        is_sub_d = (op_code == OPC_SUB_T) || (op_code == OPC_SUB_W);
        shamt_d  = imm[SHAMT_W-1:0];
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i  (op_a),
        .b_i  (opnd_b_d),
        .sub_i(is_sub_d),
        .sum_o(sum_d),
        .ovf_o(add_ovf_d)
    );

    alu_compare #(.WIDTH(WIDTH)) u_cmp (
        .a_i   (op_a),
        .b_i   (opnd_b_d),
        .lt_s_o(lt_s_d),
        .lt_u_o(lt_u_d)
    );

    alu_shift #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_shl (
        .a_i  (op_a),
        .amt_i(shamt_d),
        .y_o  (shl_d)
    );

    always_comb begin
        out_d = '{res: '0, trap: 1'b0, we: 1'b1};
        case (op_code)
            OPC_ADD_T, OPC_SUB_T: begin
                out_d.res  = sum_d;
                out_d.trap = add_ovf_d;
            end
            OPC_ADD_W, OPC_SUB_W: out_d.res = sum_d;
            OPC_LT_S:  out_d.res = {{(WIDTH-1){1'b0}}, lt_s_d};
            OPC_LT_U:  out_d.res = {{(WIDTH-1){1'b0}}, lt_u_d};
            OPC_SHL:   out_d.res = shl_d;
            default:   out_d.we  = 1'b0;
        endcase
        if (out_d.trap) out_d.we = 1'b0;
    end

    assign result   = out_d.res;
    assign ovf_trap = out_d.trap;
    assign wr_en    = out_d.we;

    always_comb begin
        if (op_code == OPC_ADD_W || op_code == OPC_SUB_W)
            assert_wrap_no_trap_R2: assert (!ovf_trap);
        if (ovf_trap)
            assert_trap_blocks_write_R6: assert (!wr_en);
        if (ovf_trap && op_code == OPC_ADD_T)
            assert_trap_sign_flip_R1: assert (result[WIDTH-1] != op_a[WIDTH-1]);
        if (op_code == OPC_LT_S || op_code == OPC_LT_U)
            assert_compare_binary_R4: assert (result[WIDTH-1:1] == '0);
        if (op_code == OPC_SHL)
            assert_shift_match_R7: assert (result == (op_a << shamt_d));
        if (op_code > OPC_SHL)
            assert_undef_quiet_R9: assert (!wr_en && !ovf_trap && result == '0);
    end
endmodule

// File: tb/sim_alu_exec_unit.sv
module sim_alu_exec_unit;
    logic        clk = 1'b0;
    logic [31:0] op_a, op_b;
    logic [15:0] imm;
    logic        imm_sel;
    logic [3:0]  op_code;
    logic [31:0] result;
    logic        ovf_trap, wr_en;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    alu_exec_unit u0 (
        .op_a(op_a), .op_b(op_b), .imm(imm), .imm_sel(imm_sel),
        .op_code(op_code), .result(result), .ovf_trap(ovf_trap), .wr_en(wr_en)
    );

    function automatic logic [31:0] model_b(logic [31:0] b, logic [15:0] im, logic sel);
        return sel ? 32'($signed(im)) : b;
    endfunction

    function automatic logic [33:0] model(logic [3:0] opc, logic [31:0] a, logic [31:0] b,
                                          logic [15:0] im, logic sel);
        logic [31:0] bb = model_b(b, im, sel);
        longint      sa = longint'($signed(a));
        longint      sb = longint'($signed(bb));
        longint      t;
        logic [31:0] r;
        logic        tr = 1'b0;
        logic        we = 1'b1;
        case (opc)
            4'd0, 4'd2: begin t = sa + sb; r = a + bb; tr = (opc == 4'd0) && (t > 64'sd2147483647 || t < -64'sd2147483648); end
            4'd1, 4'd3: begin t = sa - sb; r = a - bb; tr = (opc == 4'd1) && (t > 64'sd2147483647 || t < -64'sd2147483648); end
            4'd4: r = (sa < sb) ? 32'd1 : 32'd0;
            4'd5: r = (a < bb) ? 32'd1 : 32'd0;
            4'd6: r = a << im[4:0];
            default: begin r = 32'd0; we = 1'b0; end
        endcase
        if (tr) we = 1'b0;
        return {r, tr, we};
    endfunction

    function automatic string tag(logic [3:0] opc);
        case (opc)
            4'd0: return "R1";
            4'd1: return "R8";
            4'd2, 4'd3: return "R2";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic run(logic [3:0] opc, logic [31:0] a, logic [31:0] b,
                       logic [15:0] im, logic sel, string rq);
        logic [33:0] exp;
        @(posedge clk);
        op_code = opc; op_a = a; op_b = b; imm = im; imm_sel = sel;
        @(negedge clk);
        exp = model(opc, a, b, im, sel);
        checks++;
        if ({result, ovf_trap, wr_en} !== exp) begin
            failures++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h sel=%0b: got res=%h trap=%0b we=%0b exp res=%h trap=%0b we=%0b",
                     rq, opc, a, b, im, sel, result, ovf_trap, wr_en, exp[33:2], exp[1], exp[0]);
        end
    endtask

    initial begin
        op_a = '0; op_b = '0; imm = '0; imm_sel = 1'b0; op_code = 4'd0;
        // initial state: all-zero add
        run(4'd0, 32'h0, 32'h0, 16'h0, 1'b0, "R6");
        // R1 overflow boundaries
        run(4'd0, 32'h7fffffff, 32'h1, 16'h0, 1'b0, "R1");
        run(4'd0, 32'h80000000, 32'hffffffff, 16'h0, 1'b0, "R1");
        run(4'd0, 32'h7ffffffe, 32'h1, 16'h0, 1'b0, "R1");
        run(4'd0, 32'h7fffffff, 32'h0, 16'h0001, 1'b1, "R1 R3");
        run(4'd0, 32'h80000000, 32'h0, 16'hffff, 1'b1, "R1 R3");
        // R8 subtract boundaries
        run(4'd1, 32'h80000000, 32'h1, 16'h0, 1'b0, "R8");
        run(4'd1, 32'h7fffffff, 32'hffffffff, 16'h0, 1'b0, "R8");
        run(4'd1, 32'h0, 32'h80000000, 16'h0, 1'b0, "R8");
        run(4'd1, 32'hffffffff, 32'h80000000, 16'h0, 1'b0, "R8");
        // R2 wrapping forms at the same boundaries
        run(4'd2, 32'h7fffffff, 32'h1, 16'h0, 1'b0, "R2");
        run(4'd3, 32'h80000000, 32'h1, 16'h0, 1'b0, "R2");
        run(4'd2, 32'hffffffff, 32'h0, 16'h8000, 1'b1, "R2 R3");
        // R3 sign extension in magnitude compare: imm 0xffff -> 0xffffffff
        run(4'd5, 32'hfffffffe, 32'h0, 16'hffff, 1'b1, "R5 R3");
        run(4'd4, 32'h0, 32'h0, 16'h8000, 1'b1, "R4 R3");
        run(4'd4, 32'h80000000, 32'h7fffffff, 16'h0, 1'b0, "R4");
        run(4'd5, 32'h80000000, 32'h7fffffff, 16'h0, 1'b0, "R5");
        run(4'd4, 32'h5, 32'h5, 16'h0, 1'b0, "R4");
        // R7 every shift amount, op_b and imm_sel must not matter
        for (int s = 0; s < 32; s++)
            run(4'd6, 32'hdeadbeef, 32'hffffffff, 16'(s) | 16'hffe0, 1'(s & 1), "R7");
        // R9 undefined codes
        for (int c = 7; c < 16; c++)
            run(4'(c), 32'h12345678, 32'h9abcdef0, 16'h1234, 1'b0, "R9");
        // random mix
        void'($urandom(32'd4242));
        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  oc = 4'($urandom_range(0, 7));
            logic [31:0] a  = $urandom;
            logic [31:0] b  = $urandom;
            if (($urandom & 3) == 0) a = {a[31], {31{~a[31]}}};
            run(oc, a, b, 16'($urandom), 1'($urandom), tag(oc));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule